// File: doc/BRIEF.md
# Occupancy-Servoed Synthesized Audio Clock

This block builds a local audio master clock from a fixed reference clock with a phase-accumulator synthesizer. The accumulator adds a tuning word on every reference cycle. Its most significant bit is the synthesized clock, so the output never phase-locks to the recovered clock of the incoming stream. Sample data crosses from the recovered-clock domain into the synthesized-clock domain through an external buffer. The buffer reports its fill level to this block.

A slow servo loop keeps the two rates matched over the long term. Only once per long, fixed interval does it compare the buffer fill level with the midpoint and a deadband around it. It then nudges the tuning word up or down by one small step, or leaves it alone. The word is held inside programmable limits. Short-term jitter on the input can only move the fill level, never the synthesized edge timing directly. The loop stays idle after reset until the buffer reports that it has been prefilled.

Top module: `fifoServoClock`

## Requirements
- R1: While reset is asserted and right after it, tuneWord equals the NOMINAL_TUNE parameter, synthClk, synthTick and updateStrobe are 0, and servoRunning is 0.
- R2: The interval timer stays at zero and the tuning word never changes until prefillDone has been sampled high at a clock edge. From the following cycle servoRunning is 1, and it stays 1 until reset whatever prefillDone does.
- R3: If prefillDone is first sampled high at edge k, updateStrobe is high for exactly one cycle after edge k+INTERVAL-1. It then repeats every INTERVAL cycles. tuneWord changes only at an edge that closes a cycle with updateStrobe high.
- R4: At an update, with midpoint MID = 2^(OCC_W-1), three outcomes are possible. Occupancy greater than MID+DEADBAND raises tuneWord by STEP. Occupancy less than MID-DEADBAND lowers it by STEP. Any other occupancy leaves it unchanged.
- R5: The word produced by every update is clamped to the inclusive range [tuneMin, tuneMax].
- R6: atLimit is 1 exactly while tuneWord is greater than or equal to tuneMax or less than or equal to tuneMin.
- R7: The ACC_W-bit phase accumulator adds the current tuneWord every cycle and wraps modulo 2^ACC_W. It starts from zero at reset, and synthClk is its most significant bit.
- R8: synthTick is 1 for exactly those cycles in which synthClk is 1 and was 0 in the previous cycle.
- R9: INTERVAL equals TEST_INTERVAL when TEST_MODE is 1 and INTERVAL_CYCLES otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-frequency reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| prefillDone | input | 1 | Buffer reports it has reached its starting fill |
| occupancy | input | OCC_W | Current buffer fill level, already in this clock domain |
| tuneMin | input | ACC_W | Lower clamp for the tuning word |
| tuneMax | input | ACC_W | Upper clamp for the tuning word |
| tuneWord | output | ACC_W | Current accumulator increment |
| synthClk | output | 1 | Synthesized clock (accumulator MSB) |
| synthTick | output | 1 | One-cycle strobe on each synthClk rise |
| updateStrobe | output | 1 | High in the cycle whose closing edge applies an update |
| servoRunning | output | 1 | Servo timer has been released by prefill |
| atLimit | output | 1 | Tuning word sits at or beyond a clamp |

## Verification
The bench targets several edge cases:
- Occupancy exactly at MID+DEADBAND and MID-DEADBAND. A design with an inclusive comparison would step the word when it should hold.
- A long run with a full buffer before prefill. A timer not held would adjust a word that should still be nominal.
- Sustained full and empty stretches that drive the word into each clamp. A missing or off-by-one clamp would overshoot the limit, and the limit flag would fail to rise.
- A reset in mid-run. A design that keeps the sticky prefill state or the accumulator across reset would show a strobe or nonzero phase at once.

// File: rtl/servoPkg.sv
package servoPkg;
  // Strobes handed from the servo control to the tuning datapath.
  typedef struct packed {
    logic update;  // apply a decision at this cycle's closing edge
    logic raise;   // occupancy above the upper threshold
    logic lower;   // occupancy below the lower threshold
  } servoCmd_t;
endpackage

// File: rtl/servoCtrl.sv
module servoCtrl
  import servoPkg::*;
#(
  parameter int OCC_W    = 8,
  parameter int DEADBAND = 8,
  parameter int INTERVAL = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             prefillDone,
  input  logic [OCC_W-1:0] occupancy,
  output servoCmd_t        cmd,
  output logic             running
);
  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);
  localparam int MID = 1 << (OCC_W - 1);
  localparam logic [OCC_W:0] HI_TH = (OCC_W+1)'(MID + DEADBAND);
  localparam logic [OCC_W:0] LO_TH = (OCC_W+1)'(MID - DEADBAND);

  logic             armed;
  logic [CNT_W-1:0] timer;
  logic             atEnd;
  logic [OCC_W:0]   occX;

  // Sticky release: the timer is frozen until the buffer is prefilled.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else if (prefillDone) armed <= 1'b1;
  end

  assign atEnd = armed && (timer == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timer <= '0;
    else if (armed) timer <= atEnd ? '0 : timer + 1'b1;
  end

  assign occX = {1'b0, occupancy};

  always_comb begin
    cmd.update = atEnd;
    cmd.raise  = atEnd && (occX > HI_TH);
    cmd.lower  = atEnd && (occX < LO_TH);
  end

  assign running = armed;
endmodule

// File: rtl/servoDatapath.sv
module servoDatapath
  import servoPkg::*;
#(
  parameter int ACC_W = 32,
  parameter int STEP  = 1,
  parameter logic [ACC_W-1:0] NOMINAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  servoCmd_t        cmd,
  input  logic [ACC_W-1:0] tuneMin,
  input  logic [ACC_W-1:0] tuneMax,
  output logic [ACC_W-1:0] tuneWord,
  output logic             synthClk,
  output logic             synthTick,
  output logic             atLimit
);
  localparam logic [ACC_W:0] STEP_X = (ACC_W+1)'(STEP);

  logic [ACC_W:0]   wordX;
  logic [ACC_W:0]   target;
  logic [ACC_W-1:0] clamped;
  logic [ACC_W-1:0] phase;
  logic             msbPrev;

  assign wordX = {1'b0, tuneWord};

  // Step decision, computed one bit wider so neither direction wraps.
  always_comb begin
    if (cmd.raise)      target = wordX + STEP_X;
    else if (cmd.lower) target = (wordX < STEP_X) ? '0 : wordX - STEP_X;
    else                target = wordX;
    if (target > {1'b0, tuneMax})      clamped = tuneMax;
    else if (target < {1'b0, tuneMin}) clamped = tuneMin;
    else                               clamped = target[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tuneWord <= NOMINAL;
    else if (cmd.update) tuneWord <= clamped;
  end

  // Phase accumulator: free-running, no reference to the input clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      msbPrev <= 1'b0;
    end else begin
      phase   <= phase + tuneWord;
      msbPrev <= phase[ACC_W-1];
    end
  end

  assign synthClk  = phase[ACC_W-1];
  assign synthTick = phase[ACC_W-1] && !msbPrev;
  assign atLimit   = (tuneWord >= tuneMax) || (tuneWord <= tuneMin);
endmodule

// File: rtl/fifoServoClock.sv
module fifoServoClock
  import servoPkg::*;
#(
  parameter int ACC_W           = 32,
  parameter int OCC_W           = 8,
  parameter int DEADBAND        = 8,
  parameter int STEP            = 1,
  parameter logic [ACC_W-1:0] NOMINAL_TUNE = 32'h0E74_BC6A,
  parameter int INTERVAL_CYCLES = 500_000_000,
  parameter bit TEST_MODE       = 1'b0,
  parameter int TEST_INTERVAL   = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             prefillDone,
  input  logic [OCC_W-1:0] occupancy,
  input  logic [ACC_W-1:0] tuneMin,
  input  logic [ACC_W-1:0] tuneMax,
  output logic [ACC_W-1:0] tuneWord,
  output logic             synthClk,
  output logic             synthTick,
  output logic             updateStrobe,
  output logic             servoRunning,
  output logic             atLimit
);
  localparam int INTERVAL = TEST_MODE ? TEST_INTERVAL : INTERVAL_CYCLES;

  servoCmd_t cmd;

  servoCtrl #(
    .OCC_W(OCC_W), .DEADBAND(DEADBAND), .INTERVAL(INTERVAL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .prefillDone(prefillDone),
    .occupancy(occupancy), .cmd(cmd), .running(servoRunning)
  );

  servoDatapath #(
    .ACC_W(ACC_W), .STEP(STEP), .NOMINAL(NOMINAL_TUNE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .tuneMin(tuneMin), .tuneMax(tuneMax),
    .tuneWord(tuneWord), .synthClk(synthClk),
    .synthTick(synthTick), .atLimit(atLimit)
  );

  assign updateStrobe = cmd.update;
endmodule

// File: rtl/servoChecker.sv
module servoChecker #(
  parameter int ACC_W = 32,
  parameter int STEP  = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [ACC_W-1:0] tuneMin,
  input logic [ACC_W-1:0] tuneMax,
  input logic [ACC_W-1:0] tuneWord,
  input logic             synthClk,
  input logic             synthTick,
  input logic             updateStrobe,
  input logic             servoRunning
);
  localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);

  AST_IDLE_UNTIL_PREFILL: assert property (@(posedge clk) disable iff (!rstN)
    !servoRunning |-> !updateStrobe);  // R2

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !updateStrobe |=> $stable(tuneWord));  // R3

  AST_WORD_CLAMPED: assert property (@(posedge clk) disable iff (!rstN)
    (updateStrobe && tuneMin <= tuneMax) |=>
      (tuneWord <= $past(tuneMax) && tuneWord >= $past(tuneMin)));  // R5

  AST_SMALL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (updateStrobe && tuneWord >= tuneMin && tuneWord <= tuneMax) |=>
      ((tuneWord >= $past(tuneWord)) ? (tuneWord - $past(tuneWord) <= STEP_V)
                                     : ($past(tuneWord) - tuneWord <= STEP_V)));  // R4

  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(synthClk) |-> synthTick);  // R8

  AST_TICK_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    synthTick |-> synthClk);  // R8
endmodule

bind fifoServoClock servoChecker #(.ACC_W(ACC_W), .STEP(STEP)) u_servoChecker (
  .clk(clk), .rstN(rstN), .tuneMin(tuneMin), .tuneMax(tuneMax),
  .tuneWord(tuneWord), .synthClk(synthClk), .synthTick(synthTick),
  .updateStrobe(updateStrobe), .servoRunning(servoRunning)
);

// File: tb/test_fifoServoClock.sv
`timescale 1ns/1ps
module test_fifoServoClock;
  localparam int AW = 16;
  localparam int OW = 6;
  localparam int DB = 4;
  localparam int ST = 3;
  localparam logic [AW-1:0] NOM = 16'h1000;
  localparam int IV = 16;            // R9: TEST_MODE=1 selects TEST_INTERVAL
  localparam int MIDV = 1 << (OW - 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          prefillDone = 1'b0;
  logic [OW-1:0] occupancy = '0;
  logic [AW-1:0] tuneMin = 16'h0FF0;
  logic [AW-1:0] tuneMax = 16'h1010;
  logic [AW-1:0] tuneWord;
  logic synthClk, synthTick, updateStrobe, servoRunning, atLimit;

  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  fifoServoClock #(
    .ACC_W(AW), .OCC_W(OW), .DEADBAND(DB), .STEP(ST), .NOMINAL_TUNE(NOM),
    .INTERVAL_CYCLES(1000), .TEST_MODE(1'b1), .TEST_INTERVAL(IV)
  ) i_fifoServoClock (
    .clk(clk), .rstN(rstN), .prefillDone(prefillDone), .occupancy(occupancy),
    .tuneMin(tuneMin), .tuneMax(tuneMax), .tuneWord(tuneWord),
    .synthClk(synthClk), .synthTick(synthTick), .updateStrobe(updateStrobe),
    .servoRunning(servoRunning), .atLimit(atLimit)
  );

  // Expected next tuning word from R4 and R5.
  function automatic logic [AW-1:0] nextTune(input logic [AW-1:0] w, input int occ,
                                             input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    int t;
    t = int'(w);
    if (occ > MIDV + DB) t = t + ST;
    else if (occ < MIDV - DB) t = (t < ST) ? 0 : t - ST;
    if (t > int'(hi)) t = int'(hi);
    else if (t < int'(lo)) t = int'(lo);
    return AW'(t);
  endfunction

  // Reference model from the requirements (R2, R3, R7, R9).
  logic          mArmed;
  int            mTimer;
  logic [AW-1:0] mTune;
  logic [AW-1:0] mPhase;
  logic          mMsbPrev;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mArmed <= 1'b0; mTimer <= 0; mTune <= NOM; mPhase <= '0; mMsbPrev <= 1'b0;
    end else begin
      if (prefillDone) mArmed <= 1'b1;
      if (mArmed) mTimer <= (mTimer == IV - 1) ? 0 : mTimer + 1;
      if (mArmed && mTimer == IV - 1)
        mTune <= nextTune(mTune, int'(occupancy), tuneMin, tuneMax);
      mPhase   <= mPhase + mTune;
      mMsbPrev <= mPhase[AW-1];
    end
  end

  task automatic check1(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    logic expStrobe, expLim;
    expStrobe = mArmed && (mTimer == IV - 1);
    expLim = (mTune >= tuneMax) || (mTune <= tuneMin);
    check1("R4/R5 tuneWord", tuneWord, mTune);
    check1("R7 synthClk", synthClk, mPhase[AW-1]);
    check1("R8 synthTick", synthTick, mPhase[AW-1] && !mMsbPrev);
    check1("R3 updateStrobe", updateStrobe, expStrobe);
    check1("R2 servoRunning", servoRunning, mArmed);
    check1("R6 atLimit", atLimit, expLim);
  endtask

  task automatic run(input int n, input int mode, input int fixedOcc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkAll();
      if (mode == 0) occupancy = OW'(fixedOcc);
      else occupancy = OW'($urandom_range(0, (1 << OW) - 1));
    end
  endtask

  initial begin : watchdog
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    #35;
    check1("R1 tuneWord at reset", tuneWord, NOM);
    check1("R1 synthClk at reset", synthClk, 0);
    check1("R1 synthTick at reset", synthTick, 0);
    check1("R1 updateStrobe at reset", updateStrobe, 0);
    check1("R1 servoRunning at reset", servoRunning, 0);
    @(negedge clk); rstN = 1'b1;
    // R2: full buffer but no prefill -> no adjustment
    run(5 * IV, 0, (1 << OW) - 1);
    check1("R2 word still nominal", tuneWord, NOM);
    prefillDone = 1'b1;
    run(1, 0, MIDV);
    prefillDone = 1'b0;  // sticky: deassert must not stop the servo
    // random occupancy
    run(40 * IV, 1, 0);
    // R4: exact deadband edges hold the word
    run(4 * IV, 0, MIDV + DB);
    run(4 * IV, 0, MIDV - DB);
    run(2 * IV, 0, MIDV + DB + 1);
    run(2 * IV, 0, MIDV - DB - 1);
    // R5/R6: drive to the upper and lower clamps
    run(20 * IV, 0, (1 << OW) - 1);
    check1("R5 at upper clamp", tuneWord, tuneMax);
    check1("R6 flag at upper clamp", atLimit, 1);
    run(30 * IV, 0, 0);
    check1("R5 at lower clamp", tuneWord, tuneMin);
    check1("R6 flag at lower clamp", atLimit, 1);
    // R5: tightened limits pull the word in at the next update
    tuneMin = 16'h0FF8; tuneMax = 16'h1004;
    run(3 * IV, 0, MIDV);
    run(30 * IV, 1, 0);
    // R1/R2: reset in mid-run clears everything
    @(negedge clk); rstN = 1'b0;
    #1;
    check1("R1 word after mid reset", tuneWord, NOM);
    check1("R1 running after mid reset", servoRunning, 0);
    @(negedge clk); rstN = 1'b1;
    run(3 * IV, 1, 0);
    prefillDone = 1'b1;
    run(20 * IV, 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule